// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block turns one flash operation request into the strobe pattern a raw NAND bus expects: command-latch and address-latch write cycles with chip enable held low, followed by any confirm command and hold-off the operation calls for. A request carries an opcode, an optional column, an optional row and a page-size flag. The sequencer rewrites opcodes and address bytes where needed. It emulates spare-area reads on large-page parts, selects the area pointer on small-page parts, halves the column on a 16-bit bus and appends confirm commands. It does all of this before any cycle is driven.

When the operation needs the device to become ready again, the block signals a one-cycle hand-off to a separate ready-wait unit. The hand-off says whether that unit should watch the ready/busy pin or poll the status register. Data-phase transfers are not part of this block. Setup, write-pulse and hold lengths are set in clocks by parameters. The two fixed waits are the column-change hold-off, given in nanoseconds, and the chip delay used when no ready pin exists.

Top module: `nand_cmd_seq`

## Requirements
- R1: In large-page mode a spare-read request (0x50) goes out as a READ0 command (0x00) whose column is increased by the large page size. Two column bytes follow, low byte first. When a large-page READ0 carried any address cycle, a READSTART command (0x30) follows it and the hand-off kind is ready-pin wait. A small-page READ0 with an address gets no READSTART.
- R2: In small-page mode a program-data-input request (0x80) is preceded by a pointer command chosen from the column. A column at or above the small page size selects 0x50, with the page size subtracted from the column. A column below 256 selects 0x00. Any other column selects 0x01, with 256 subtracted. Small-page mode sends one column byte.
- R3: With the 16-bit bus enabled the column is shifted right by one before it is sent. This does not apply to the 8-bit-address opcodes 0x90, 0xEC, 0xEE and 0xEF, which keep their column as given and send only one column byte.
- R4: The row goes out as two bytes, low byte first, plus a third byte holding row bits 23:16 when `cfg_row3` is set.
- R5: A READ0 with neither column nor row is sent as a single command cycle and produces no hand-off.
- R6: In large-page mode a column-change read (0x05) is followed after its address by the confirm command 0xE0. A hold-off of at least the column-change time then follows (500 ns when `TCCS_NS` is 0), and there is no hand-off.
- R7: Opcodes 0x10, 0x15, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF finish with no hand-off and no wait.
- R8: A reset (0xFF) with `cfg_rb_present` set hands off as a ready-pin wait. Without it, the block waits `CHIP_DLY_CYC` clocks, sends a status command (0x70) and hands off as a status poll. Any other opcode without a ready pin ends with the chip delay and no hand-off.
- R9: In every latch cycle exactly one of CLE and ALE is high. It is raised `T_SU` clocks before WE# falls, WE# stays low `T_WP` clocks, and CLE or ALE stays high `T_H` clocks after WE# rises. The bus carries the byte on I/O[7:0] with I/O[15:8] at zero.
- R10: `busy` rises the cycle after a request is accepted and stays high until the sequence ends. Chip enable is low exactly while busy. A request offered while busy is ignored, and with no sequence running, WE#, CLE and ALE are inactive.
- R11: The hand-off is a one-cycle `hand_valid` pulse in the last busy cycle, with `hand_kind` 01 for ready-pin wait and 10 for status poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bus16 | input | 1 | Device uses the 16-bit bus |
| cfg_row3 | input | 1 | Send a third row byte |
| cfg_rb_present | input | 1 | A ready/busy pin is available |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_large_page | input | 1 | 1 = large-page sequencing, 0 = small-page |
| req_op | input | 8 | Operation opcode |
| req_has_col | input | 1 | Column is present |
| req_col | input | COL_W | Column address |
| req_has_row | input | 1 | Row is present |
| req_row | input | 24 | Row (page) address |
| busy | output | 1 | Sequence in progress |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | IO_W | I/O bus value |
| nand_io_oe | output | 1 | I/O bus output enable |
| hand_valid | output | 1 | Hand-off pulse to the ready-wait unit |
| hand_kind | output | 2 | 01 ready pin, 10 status poll |

## Verification
The bus is watched at every WE# rising edge and the latched bytes are compared with a list derived by hand from the rules. Spare reads check the column offset and the confirm command. Three program-input columns, one on each side of both pointer thresholds, check the pointer choice and the column correction. A 16-bit column set against an ID read shows where halving stops and where the single column byte applies. Reset with and without a ready pin, a bare READ0, the column-change read and the no-wait opcodes separate the four endings by their hand-off pulse and by their measured gap lengths. A request offered during a long reset must leave no trace on the bus.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

   localparam logic [7:0] OP_READ0       = 8'h00;
   localparam logic [7:0] OP_READ1       = 8'h01;
   localparam logic [7:0] OP_RNDOUT      = 8'h05;
   localparam logic [7:0] OP_PAGEPROG    = 8'h10;
   localparam logic [7:0] OP_CACHEPROG   = 8'h15;
   localparam logic [7:0] OP_READSTART   = 8'h30;
   localparam logic [7:0] OP_READOOB     = 8'h50;
   localparam logic [7:0] OP_ERASE1      = 8'h60;
   localparam logic [7:0] OP_STATUS      = 8'h70;
   localparam logic [7:0] OP_SEQIN       = 8'h80;
   localparam logic [7:0] OP_READID      = 8'h90;
   localparam logic [7:0] OP_ERASE2      = 8'hD0;
   localparam logic [7:0] OP_RNDOUTSTART = 8'hE0;
   localparam logic [7:0] OP_PARAM       = 8'hEC;
   localparam logic [7:0] OP_GETFEAT     = 8'hEE;
   localparam logic [7:0] OP_SETFEAT     = 8'hEF;
   localparam logic [7:0] OP_RESET       = 8'hFF;

   // longest list: command, two column, three row, confirm, hold-off, status
   localparam int MAX_STEPS = 9;
   localparam int IDX_W     = $clog2(MAX_STEPS + 1);

   typedef enum logic [1:0] {
      ST_CMD      = 2'd0,
      ST_ADDR     = 2'd1,
      ST_DLY_CCS  = 2'd2,
      ST_DLY_CHIP = 2'd3
   } step_kind_e;

   typedef struct packed {
      step_kind_e kind;
      logic [7:0] val;
   } step_t;

   typedef enum logic [1:0] {
      HO_NONE  = 2'b00,
      HO_READY = 2'b01,
      HO_POLL  = 2'b10
   } handoff_e;

   function automatic logic addr8_only(input logic [7:0] op);
      return (op == OP_READID) || (op == OP_PARAM) ||
             (op == OP_GETFEAT) || (op == OP_SETFEAT);
   endfunction

   function automatic logic ends_unwaited(input logic [7:0] op);
      return (op == OP_CACHEPROG) || (op == OP_PAGEPROG) || (op == OP_ERASE1) ||
             (op == OP_ERASE2) || (op == OP_SEQIN) || (op == OP_STATUS) ||
             (op == OP_READID) || (op == OP_SETFEAT);
   endfunction

endpackage

// File: rtl/nseq_plan.sv
module nseq_plan
   import nseq_pkg::*;
#(
   parameter int COL_W   = 16,
   parameter int LP_PAGE = 2048,
   parameter int SP_PAGE = 512
) (
   input  logic [7:0]                 op_i,
   input  logic [COL_W-1:0]           col_i,
   input  logic                       has_col_i,
   input  logic [23:0]                row_i,
   input  logic                       has_row_i,
   input  logic                       large_i,
   input  logic                       bus16_i,
   input  logic                       row3_i,
   input  logic                       rb_i,
   output step_t [MAX_STEPS-1:0]      steps_o,
   output logic  [IDX_W-1:0]          count_o,
   output handoff_e                   hand_o
);

   logic [7:0]       op;
   logic [7:0]       ptr;
   logic [15:0]      cx;
   logic [15:0]      cs;
   logic [IDX_W-1:0] n;
   logic             narrow;

   always_comb begin
      steps_o = '0;
      hand_o  = HO_NONE;
      n       = '0;
      op      = op_i;
      ptr     = OP_READ0;
      cx      = 16'(col_i);
      // large page: spare read becomes READ0 past the data area
      if (large_i && op_i == OP_READOOB) begin
         cx = cx + 16'(LP_PAGE);
         op = OP_READ0;
      end
      // small page: pointer ahead of program data input
      if (!large_i && op_i == OP_SEQIN) begin
         if (cx >= 16'(SP_PAGE)) begin
            ptr = OP_READOOB;
            cx  = cx - 16'(SP_PAGE);
         end else if (cx < 16'd256) begin
            ptr = OP_READ0;
         end else begin
            ptr = OP_READ1;
            cx  = cx - 16'd256;
         end
         steps_o[n] = '{ST_CMD, ptr};
         n = n + 1'b1;
      end
      steps_o[n] = '{ST_CMD, op};
      n = n + 1'b1;
      narrow = addr8_only(op);
      cs = (bus16_i && !narrow) ? (cx >> 1) : cx;
      if (has_col_i) begin
         steps_o[n] = '{ST_ADDR, cs[7:0]};
         n = n + 1'b1;
         if (large_i && !narrow) begin
            steps_o[n] = '{ST_ADDR, cs[15:8]};
            n = n + 1'b1;
         end
      end
      if (has_row_i) begin
         steps_o[n] = '{ST_ADDR, row_i[7:0]};
         n = n + 1'b1;
         steps_o[n] = '{ST_ADDR, row_i[15:8]};
         n = n + 1'b1;
         if (row3_i) begin
            steps_o[n] = '{ST_ADDR, row_i[23:16]};
            n = n + 1'b1;
         end
      end
      // ending of the operation
      if (ends_unwaited(op)) begin
         hand_o = HO_NONE;
      end else if (op == OP_RESET) begin
         if (rb_i) begin
            hand_o = HO_READY;
         end else begin
            steps_o[n] = '{ST_DLY_CHIP, 8'h00};
            n = n + 1'b1;
            steps_o[n] = '{ST_CMD, OP_STATUS};
            n = n + 1'b1;
            hand_o = HO_POLL;
         end
      end else if (large_i && op == OP_RNDOUT) begin
         steps_o[n] = '{ST_CMD, OP_RNDOUTSTART};
         n = n + 1'b1;
         steps_o[n] = '{ST_DLY_CCS, 8'h00};
         n = n + 1'b1;
      end else if (op == OP_READ0 && !has_col_i && !has_row_i) begin
         hand_o = HO_NONE;
      end else begin
         if (large_i && op == OP_READ0) begin
            steps_o[n] = '{ST_CMD, OP_READSTART};
            n = n + 1'b1;
         end
         if (rb_i) begin
            hand_o = HO_READY;
         end else begin
            steps_o[n] = '{ST_DLY_CHIP, 8'h00};
            n = n + 1'b1;
         end
      end
      count_o = n;
   end

endmodule

// File: rtl/nseq_step.sv
module nseq_step
   import nseq_pkg::*;
#(
   parameter int IO_W     = 16,
   parameter int T_SU     = 2,
   parameter int T_WP     = 2,
   parameter int T_H      = 2,
   parameter int CCS_CYC  = 25,
   parameter int CHIP_CYC = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active_i,
   input  step_t           step_i,
   output logic            fin_o,
   output logic            cle_o,
   output logic            ale_o,
   output logic            we_n_o,
   output logic            oe_o,
   output logic [IO_W-1:0] io_o
);

   localparam int BUS_LEN = T_SU + T_WP + T_H;
   localparam int LEN_A   = (BUS_LEN > CCS_CYC) ? BUS_LEN : CCS_CYC;
   localparam int MAX_LEN = (LEN_A > CHIP_CYC) ? LEN_A : CHIP_CYC;
   localparam int CW      = $clog2(MAX_LEN + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;
   logic          is_bus;

   always_comb begin
      case (step_i.kind)
         ST_DLY_CCS:  last = CW'(CCS_CYC - 1);
         ST_DLY_CHIP: last = CW'(CHIP_CYC - 1);
         default:     last = CW'(BUS_LEN - 1);
      endcase
   end

   assign fin_o = active_i && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!active_i || fin_o) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
   end

   assign is_bus = active_i && (step_i.kind == ST_CMD || step_i.kind == ST_ADDR);
   assign cle_o  = active_i && (step_i.kind == ST_CMD);
   assign ale_o  = active_i && (step_i.kind == ST_ADDR);
   assign oe_o   = is_bus;
   assign we_n_o = !(is_bus && cnt >= CW'(T_SU) && cnt < CW'(T_SU + T_WP));
   assign io_o   = is_bus ? IO_W'(step_i.val) : '0;

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nseq_pkg::*;
#(
   parameter int IO_W         = 16,
   parameter int COL_W        = 16,
   parameter int LP_PAGE      = 2048,
   parameter int SP_PAGE      = 512,
   parameter int CLK_NS       = 20,
   parameter int TCCS_NS      = 0,
   parameter int CHIP_DLY_CYC = 40,
   parameter int T_SU         = 2,
   parameter int T_WP         = 2,
   parameter int T_H          = 2,
   parameter bit OUT_REG      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_bus16,
   input  logic             cfg_row3,
   input  logic             cfg_rb_present,
   input  logic             req_valid,
   input  logic             req_large_page,
   input  logic [7:0]       req_op,
   input  logic             req_has_col,
   input  logic [COL_W-1:0] req_col,
   input  logic             req_has_row,
   input  logic [23:0]      req_row,
   output logic             busy,
   output logic             nand_ce_n,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_we_n,
   output logic [IO_W-1:0]  nand_io,
   output logic             nand_io_oe,
   output logic             hand_valid,
   output logic [1:0]       hand_kind
);

   localparam int CCS_NS  = (TCCS_NS == 0) ? 500 : TCCS_NS;
   localparam int CCS_CYC = (CCS_NS + CLK_NS - 1) / CLK_NS;

   if (IO_W != 8 && IO_W != 16) begin : g_bad_io
      $error("IO_W must be 8 or 16");
   end
   if (COL_W > 16 || (1 << COL_W) <= 2 * LP_PAGE) begin : g_bad_col
      $error("COL_W must hold twice the large page size and be at most 16");
   end
   if (T_SU < 1 || T_WP < 1 || T_H < 1 || CHIP_DLY_CYC < 1) begin : g_bad_tim
      $error("timing counts must be at least one clock");
   end

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;

   state_e                  state;
   step_t [MAX_STEPS-1:0]   plan_steps, steps_q;
   logic  [IDX_W-1:0]       plan_cnt, last_q, idx;
   handoff_e                plan_hand, hand_q;
   logic                    accept, fin, bus16;
   logic                    c_cle, c_ale, c_we_n, c_oe;
   logic [IO_W-1:0]         c_io;

   assign bus16  = (IO_W == 16) && cfg_bus16;
   assign accept = req_valid && (state == S_IDLE);

   nseq_plan #(.COL_W(COL_W), .LP_PAGE(LP_PAGE), .SP_PAGE(SP_PAGE)) u_plan (
      .op_i(req_op), .col_i(req_col), .has_col_i(req_has_col),
      .row_i(req_row), .has_row_i(req_has_row), .large_i(req_large_page),
      .bus16_i(bus16), .row3_i(cfg_row3), .rb_i(cfg_rb_present),
      .steps_o(plan_steps), .count_o(plan_cnt), .hand_o(plan_hand)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         steps_q <= '0;
         last_q  <= '0;
         idx     <= '0;
         hand_q  <= HO_NONE;
      end else begin
         case (state)
            S_IDLE: if (accept) begin
               steps_q <= plan_steps;
               last_q  <= plan_cnt - 1'b1;
               hand_q  <= plan_hand;
               idx     <= '0;
               state   <= S_RUN;
            end
            S_RUN: if (fin) begin
               if (idx == last_q) state <= S_DONE;
               else               idx   <= idx + 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   nseq_step #(.IO_W(IO_W), .T_SU(T_SU), .T_WP(T_WP), .T_H(T_H),
               .CCS_CYC(CCS_CYC), .CHIP_CYC(CHIP_DLY_CYC)) u_step (
      .clk(clk), .rst_n(rst_n), .active_i(state == S_RUN),
      .step_i(steps_q[idx]), .fin_o(fin),
      .cle_o(c_cle), .ale_o(c_ale), .we_n_o(c_we_n), .oe_o(c_oe), .io_o(c_io)
   );

   assign busy       = (state != S_IDLE);
   assign nand_ce_n  = !busy;
   assign hand_valid = (state == S_DONE) && (hand_q != HO_NONE);
   assign hand_kind  = (state == S_DONE) ? hand_q : HO_NONE;

   if (OUT_REG) begin : g_pin_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            nand_cle   <= 1'b0;
            nand_ale   <= 1'b0;
            nand_we_n  <= 1'b1;
            nand_io_oe <= 1'b0;
            nand_io    <= '0;
         end else begin
            nand_cle   <= c_cle;
            nand_ale   <= c_ale;
            nand_we_n  <= c_we_n;
            nand_io_oe <= c_oe;
            nand_io    <= c_io;
         end
      end
   end else begin : g_pin_comb
      assign nand_cle   = c_cle;
      assign nand_ale   = c_ale;
      assign nand_we_n  = c_we_n;
      assign nand_io_oe = c_oe;
      assign nand_io    = c_io;
   end

endmodule

// File: rtl/nseq_check.sv
module nseq_check #(
   parameter int T_WP = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       nand_ce_n,
   input logic       nand_cle,
   input logic       nand_ale,
   input logic       nand_we_n,
   input logic       nand_io_oe,
   input logic       hand_valid,
   input logic [1:0] hand_kind
);

   logic [7:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_cnt <= '0;
      else if (!nand_we_n) low_cnt <= low_cnt + 1'b1;
      else                 low_cnt <= '0;
   end

   p_latch_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   p_we_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> ((nand_cle || nand_ale) && nand_io_oe && !nand_ce_n));

   p_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_we_n) |-> $past(nand_cle || nand_ale));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> ((nand_cle || nand_ale) && $stable(nand_cle) && $stable(nand_ale)));

   p_we_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> (low_cnt == 8'(T_WP)));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (nand_we_n && !nand_cle && !nand_ale));

   p_hand_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hand_valid |=> !busy);

   p_hand_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hand_valid |-> (busy && (hand_kind == 2'b01 || hand_kind == 2'b10)));

endmodule

bind nand_cmd_seq nseq_check #(.T_WP(T_WP)) u_nseq_check (
   .clk(clk), .rst_n(rst_n), .busy(busy), .nand_ce_n(nand_ce_n),
   .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
   .nand_io_oe(nand_io_oe), .hand_valid(hand_valid), .hand_kind(hand_kind)
);

// File: tb/sim_nand_cmd_seq.sv
`timescale 1ns/1ps
module sim_nand_cmd_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_bus16 = 1'b0, cfg_row3 = 1'b0, cfg_rb_present = 1'b1;
   logic        req_valid = 1'b0, req_large_page = 1'b1;
   logic [7:0]  req_op = 8'h00;
   logic        req_has_col = 1'b0, req_has_row = 1'b0;
   logic [15:0] req_col = '0;
   logic [23:0] req_row = '0;
   logic        busy, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_io_oe, hand_valid;
   logic [15:0] nand_io;
   logic [1:0]  hand_kind;

   always #10 clk = ~clk;   // 50 MHz

   nand_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16), .cfg_row3(cfg_row3),
      .cfg_rb_present(cfg_rb_present), .req_valid(req_valid),
      .req_large_page(req_large_page), .req_op(req_op), .req_has_col(req_has_col),
      .req_col(req_col), .req_has_row(req_has_row), .req_row(req_row),
      .busy(busy), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_io(nand_io), .nand_io_oe(nand_io_oe),
      .hand_valid(hand_valid), .hand_kind(hand_kind)
   );

   int checks = 0, fails = 0;
   int cyc = 0, busy_end = 0;
   logic [8:0] lg [0:31];
   int lg_cyc [0:31];
   int lg_n = 0, low_w = 0, hand_n = 0;
   logic [1:0] hand_k = 2'b00;
   logic we_prev = 1'b1;
   logic [8:0] ex [0:31];
   int ex_n = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // bus monitor: record each latched byte at the WE# rising edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!nand_we_n) low_w++;
         if (!we_prev && nand_we_n) begin
            if (lg_n < 32) begin
               lg[lg_n] = {nand_cle, nand_io[7:0]};
               lg_cyc[lg_n] = cyc;
            end
            lg_n++;
            chk(low_w == 2, "R9 WE# low width", low_w, 2);
            chk(nand_io[15:8] == 8'h00 && (nand_cle ^ nand_ale) && !nand_ce_n,
                "R9 upper byte zero, one latch, CE low", {nand_io[15:8], nand_cle, nand_ale}, 1);
            low_w = 0;
         end
         if (hand_valid) begin
            hand_n++;
            hand_k = hand_kind;
         end
      end
      we_prev = nand_we_n;
   end

   task automatic ex_clear();
      ex_n = 0;
   endtask

   task automatic ex_add(input bit is_cmd, input logic [7:0] b);
      ex[ex_n] = {is_cmd, b};
      ex_n++;
   endtask

   task automatic issue(input logic [7:0] op, input logic [15:0] col, input bit hc,
                        input logic [23:0] row, input bit hr, input bit lp);
      @(negedge clk);
      lg_n = 0; hand_n = 0; hand_k = 2'b00;
      req_op = op; req_col = col; req_has_col = hc;
      req_row = row; req_has_row = hr; req_large_page = lp; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_op();
      while (busy) @(negedge clk);
      busy_end = cyc;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_op(input logic [7:0] op, input logic [15:0] col, input bit hc,
                         input logic [23:0] row, input bit hr, input bit lp);
      issue(op, col, hc, row, hr, lp);
      chk(busy == 1'b1 && nand_ce_n == 1'b0, "R10 busy and CE after accept", busy, 1);
      finish_op();
   endtask

   task automatic check_seq(input string tag);
      chk(lg_n == ex_n, {tag, " latch count"}, lg_n, ex_n);
      for (int i = 0; i < ex_n && i < lg_n; i++)
         chk(lg[i] == ex[i], {tag, " latched byte"}, lg[i], ex[i]);
   endtask

   task automatic check_hand(input string tag, input int n, input logic [1:0] k);
      chk(hand_n == n, {tag, " hand-off count"}, hand_n, n);
      if (n > 0) chk(hand_k == k, {tag, " hand-off kind"}, hand_k, k);
   endtask

   task automatic t_reset_state();
      chk(busy == 0 && nand_ce_n == 1 && nand_we_n == 1 && nand_cle == 0 &&
          nand_ale == 0 && hand_valid == 0, "R10 reset state",
          {busy, nand_ce_n, nand_we_n, nand_cle, nand_ale, hand_valid}, 6'b011000);
   endtask

   task automatic t_lp_spare_read();   // R1, R4
      cfg_bus16 = 0; cfg_row3 = 1; cfg_rb_present = 1;
      run_op(8'h50, 16'h0010, 1, 24'h012345, 1, 1);
      ex_clear(); ex_add(1, 8'h00); ex_add(0, 8'h10); ex_add(0, 8'h08);
      ex_add(0, 8'h45); ex_add(0, 8'h23); ex_add(0, 8'h01); ex_add(1, 8'h30);
      check_seq("R1 R4 large-page spare read");
      check_hand("R1 R11 spare read", 1, 2'b01);
   endtask

   task automatic t_lp_read16();       // R3, R4
      cfg_bus16 = 1; cfg_row3 = 0;
      run_op(8'h00, 16'h0102, 1, 24'h00BEEF, 1, 1);
      ex_clear(); ex_add(1, 8'h00); ex_add(0, 8'h81); ex_add(0, 8'h00);
      ex_add(0, 8'hEF); ex_add(0, 8'hBE); ex_add(1, 8'h30);
      check_seq("R3 R4 16-bit read, two row bytes");
      check_hand("R1 16-bit read", 1, 2'b01);
   endtask

   task automatic t_readid16();        // R3, R7
      cfg_bus16 = 1;
      run_op(8'h90, 16'h0020, 1, 24'h0, 0, 1);
      ex_clear(); ex_add(1, 8'h90); ex_add(0, 8'h20);
      check_seq("R3 ID read keeps column, one byte");
      check_hand("R7 ID read", 0, 2'b00);
      cfg_bus16 = 0;
   endtask

   task automatic t_sp_prog_inputs();  // R2, R7
      run_op(8'h80, 16'h0010, 1, 24'h000A0B, 1, 0);
      ex_clear(); ex_add(1, 8'h00); ex_add(1, 8'h80); ex_add(0, 8'h10);
      ex_add(0, 8'h0B); ex_add(0, 8'h0A);
      check_seq("R2 pointer READ0 for low column");
      check_hand("R7 program input", 0, 2'b00);
      run_op(8'h80, 16'h0120, 1, 24'h0, 0, 0);
      ex_clear(); ex_add(1, 8'h01); ex_add(1, 8'h80); ex_add(0, 8'h20);
      check_seq("R2 pointer READ1 for upper half");
      run_op(8'h80, 16'h0205, 1, 24'h0, 0, 0);
      ex_clear(); ex_add(1, 8'h50); ex_add(1, 8'h80); ex_add(0, 8'h05);
      check_seq("R2 pointer spare for column past page");
   endtask

   task automatic t_sp_read();         // R1 small-page contrast
      run_op(8'h00, 16'h0033, 1, 24'h000102, 1, 0);
      ex_clear(); ex_add(1, 8'h00); ex_add(0, 8'h33); ex_add(0, 8'h02); ex_add(0, 8'h01);
      check_seq("R1 small-page READ0 no confirm");
      check_hand("R1 small-page READ0", 1, 2'b01);
   endtask

   task automatic t_bare_read0();      // R5
      run_op(8'h00, 16'h0, 0, 24'h0, 0, 1);
      ex_clear(); ex_add(1, 8'h00);
      check_seq("R5 bare READ0");
      check_hand("R5 bare READ0", 0, 2'b00);
   endtask

   task automatic t_rndout();          // R6
      run_op(8'h05, 16'h0123, 1, 24'h0, 0, 1);
      ex_clear(); ex_add(1, 8'h05); ex_add(0, 8'h23); ex_add(0, 8'h01); ex_add(1, 8'hE0);
      check_seq("R6 column-change read");
      check_hand("R6 column-change read", 0, 2'b00);
      if (lg_n >= 4)
         chk(busy_end - lg_cyc[3] >= 25 && busy_end - lg_cyc[3] <= 33,
             "R6 hold-off after confirm", busy_end - lg_cyc[3], 25);
   endtask

   task automatic t_no_wait_ops();     // R7
      cfg_row3 = 0;
      run_op(8'h60, 16'h0, 0, 24'h004455, 1, 1);
      ex_clear(); ex_add(1, 8'h60); ex_add(0, 8'h55); ex_add(0, 8'h44);
      check_seq("R7 erase setup");
      check_hand("R7 erase setup", 0, 2'b00);
      run_op(8'h10, 16'h0, 0, 24'h0, 0, 1);
      ex_clear(); ex_add(1, 8'h10);
      check_seq("R7 page program");
      check_hand("R7 page program", 0, 2'b00);
   endtask

   task automatic t_reset_ops();       // R8
      cfg_rb_present = 1;
      run_op(8'hFF, 16'h0, 0, 24'h0, 0, 1);
      ex_clear(); ex_add(1, 8'hFF);
      check_seq("R8 reset with ready pin");
      check_hand("R8 R11 reset with ready pin", 1, 2'b01);
      cfg_rb_present = 0;
      run_op(8'hFF, 16'h0, 0, 24'h0, 0, 1);
      ex_clear(); ex_add(1, 8'hFF); ex_add(1, 8'h70);
      check_seq("R8 reset without ready pin");
      check_hand("R8 R11 reset without ready pin", 1, 2'b10);
      // hold 2 + chip delay 40 + setup 2 + pulse 2
      if (lg_n >= 2) chk(lg_cyc[1] - lg_cyc[0] == 46, "R8 chip delay gap",
                         lg_cyc[1] - lg_cyc[0], 46);
      run_op(8'h01, 16'h0044, 1, 24'h0, 0, 0);
      ex_clear(); ex_add(1, 8'h01); ex_add(0, 8'h44);
      check_seq("R8 read without ready pin");
      check_hand("R8 read without ready pin", 0, 2'b00);
      cfg_rb_present = 1;
   endtask

   task automatic t_busy_ignore();     // R10
      bit rose = 0;
      cfg_rb_present = 0;
      issue(8'hFF, 16'h0, 0, 24'h0, 0, 1);
      repeat (10) @(negedge clk);
      req_op = 8'h00; req_has_col = 1; req_col = 16'h0077; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      finish_op();
      for (int i = 0; i < 10; i++) begin
         if (busy) rose = 1;
         @(negedge clk);
      end
      ex_clear(); ex_add(1, 8'hFF); ex_add(1, 8'h70);
      check_seq("R10 request while busy ignored");
      chk(!rose, "R10 no sequence after ignored request", rose, 0);
      cfg_rb_present = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_lp_spare_read();
      t_lp_read16();
      t_readid16();
      t_sp_prog_inputs();
      t_sp_read();
      t_bare_read0();
      t_rndout();
      t_no_wait_ops();
      t_reset_ops();
      t_busy_ignore();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule